// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is the processor-facing controller of a small two-way set-associative data cache with 64 sets of 8-word lines. The processor issues one word load or store at a time; the controller looks up both ways of the indexed set. On a hit it returns the word or writes it. On a miss it either reads one word from the bus or fills the whole line through a simple word-wide bus handshake, and it first writes back a dirty victim line. Each set keeps one replacement bit, and each line keeps a valid bit and a dirty bit.

The store policy is chosen for each access when the request is accepted. When translation is on, the page attribute input chooses the policy. When translation is off, one bit of a 32-bit region mask chooses it, indexed by the top five address bits. A configuration input can make load misses fetch a single word without allocating a line. The processor sees `cpu_ready` pulse for one cycle when its request is done, and it holds the request until then.

The control is a single state machine:
- `ST_IDLE`: waits for `cpu_req` and captures the request and its policy.
- `ST_LOOK`: compares tags and picks the next state. A hit goes to `ST_REPLY`, or to `ST_WTHRU` for a write-through store. A non-allocating load miss goes to `ST_SINGLE`. Any other miss goes to `ST_EVICT` when the victim is dirty and to `ST_REFILL` otherwise.
- `ST_EVICT`: runs 8 bus writes, then goes to `ST_REFILL`.
- `ST_REFILL`: runs 8 bus reads, then goes back to `ST_LOOK`.
- `ST_SINGLE` and `ST_WTHRU`: each runs one bus transfer, then goes to `ST_REPLY`.
- `ST_REPLY`: raises ready, then goes to `ST_IDLE`.

Top module: `wb_dcache_ctrl`

## Requirements
- R1: A load hit returns its data on `cpu_rdata` with `cpu_ready` high exactly two cycles after the accepting edge. A store hit under write-back completes with the same timing.
- R2: After reset all lines are invalid and every replacement bit selects way 0. The victim of a fill is the way that the replacement bit selects. After a fill or a hit, the bit selects the other way.
- R3: A store hit under write-back updates the cached word and marks the line dirty, with no bus transfer. A later load returns the stored value.
- R4: A store hit under write-through updates the cached word and makes exactly one bus write of that word. The dirty bit keeps its value.
- R5: The policy is write-through when `xlate_on`=1 and `page_wt`=1. It is also write-through when `xlate_on`=0 and bit `addr[31:27]` of `region_wt` is 1, where bit 0 covers the lowest 128MB. In all other cases the policy is write-back.
- R6: With `load_noalloc`=1, a load miss makes one bus read of the requested word and allocates nothing. A repeated load of that address therefore reads the bus again. Load hits are unaffected.
- R7: With `load_noalloc`=0, a load miss reads the 8 words of the line in order from word 0 to word 7, installs the line, and then serves the load.
- R8: If the victim line is valid and dirty, its 8 words are written to the bus at its old address, in order from word 0 to word 7, before the fill reads begin.
- R9: A store miss allocates the line like a load miss does, and is then applied as a store hit under its policy.
- R10: After reset, and between requests, `cpu_ready` and `bus_req` are low. `cpu_ready` is high for a single cycle for each request.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we` and `bus_addr` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 30 | Word address, byte address bits [31:2] |
| cpu_wdata | input | 32 | Store data |
| xlate_on | input | 1 | Address translation is enabled |
| page_wt | input | 1 | Page write-through attribute |
| region_wt | input | 32 | Write-through mask for 128MB regions, used when translation is off |
| load_noalloc | input | 1 | Load misses read one word without allocating |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = bus write |
| bus_addr | output | 30 | Bus word address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | One-cycle acknowledge of the current transfer |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |

## Verification
The assertions rely on three things about the inputs. The bus acknowledges only a transfer that is being requested, and holds `bus_ack` high for at most one cycle. The processor holds its request until ready and lowers it in the cycle after ready. The policy and configuration inputs may change between requests. The bench's bus model acknowledges after a varying wait of zero to two cycles and always drops the acknowledge for the following cycle. The processor driver raises a request only from the idle state and lowers it when it sees the ready pulse.

// File: rtl/wbdc_pkg.sv
package wbdc_pkg;
    parameter int ADDR_W     = 32;
    parameter int DATA_W     = 32;
    parameter int SETS       = 64;
    parameter int LINE_WORDS = 8;
    parameter int WAYS       = 2;
    parameter int REGIONS    = 32;

    localparam int WORD_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WORD_W + 2;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int REG_W  = $clog2(REGIONS);
    localparam int IDX_W  = SET_W + 1 + WORD_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_EVICT,
        ST_REFILL,
        ST_SINGLE,
        ST_WTHRU,
        ST_REPLY
    } ctl_state_t;
endpackage

// File: rtl/wbdc_policy.sv
module wbdc_policy
    import wbdc_pkg::*;
(
    input  logic               xlate_on,
    input  logic               page_wt,
    input  logic [REGIONS-1:0] region_wt,
    input  logic [REG_W-1:0]   region_ix,
    output logic               thru
);
    // translated pages carry their own attribute; real mode looks up the mask
    always_comb begin
        if (xlate_on) thru = page_wt;
        else          thru = region_wt[region_ix];
    end
endmodule

// File: rtl/wbdc_tags.sv
module wbdc_tags
    import wbdc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             set_i,
    input  logic [TAG_W-1:0]             tag_i,
    input  logic                         alloc_en,
    input  logic                         alloc_way,
    input  logic                         dirty_en,
    input  logic                         dirty_way,
    input  logic                         touch_en,
    input  logic                         touch_way,
    output logic [WAYS-1:0]              hit_vec,
    output logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    output logic [WAYS-1:0]              way_valid,
    output logic [WAYS-1:0]              way_dirty,
    output logic                         lru_way
);
    logic [TAG_W-1:0]           tag_mem [SETS][WAYS];
    logic [SETS-1:0][WAYS-1:0]  vld_q;
    logic [SETS-1:0][WAYS-1:0]  drt_q;
    logic [SETS-1:0]            lru_q;

    always_ff @(posedge clk) begin
        if (alloc_en) tag_mem[set_i][alloc_way] <= tag_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            drt_q <= '0;
            lru_q <= '0;
        end else begin
            if (alloc_en) begin
                vld_q[set_i][alloc_way] <= 1'b1;
                drt_q[set_i][alloc_way] <= 1'b0;
                lru_q[set_i]            <= ~alloc_way;
            end
            if (dirty_en) drt_q[set_i][dirty_way] <= 1'b1;
            if (touch_en) lru_q[set_i]            <= ~touch_way;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_tag[w]   = tag_mem[set_i][w];
        assign way_valid[w] = vld_q[set_i][w];
        assign way_dirty[w] = drt_q[set_i][w];
        assign hit_vec[w]   = vld_q[set_i][w] && (tag_mem[set_i][w] == tag_i);
    end

    assign lru_way = lru_q[set_i];
endmodule

// File: rtl/wbdc_data.sv
module wbdc_data
    import wbdc_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [SET_W-1:0]  set_i,
    input  logic              way_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = SETS * WAYS * LINE_WORDS;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx   = {set_i, way_i, word_i};
    assign rdata = store_q[idx];

    always_ff @(posedge clk) begin
        if (we) store_q[idx] <= wdata;
    end
endmodule

// File: rtl/wb_dcache_ctrl.sv
module wb_dcache_ctrl
    import wbdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:2]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               xlate_on,
    input  logic               page_wt,
    input  logic [REGIONS-1:0] region_wt,
    input  logic               load_noalloc,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:2]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_rdata
);
    ctl_state_t state_q, state_d;

    // captured request
    logic [ADDR_W-1:2] req_addr_q;
    logic              req_we_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              req_thru_q;
    logic              req_noalloc_q;
    logic              way_q;
    logic [WORD_W-1:0] beat_q;
    logic [DATA_W-1:0] rdata_q;

    logic              cur_thru;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    logic [WORD_W-1:0] req_word;

    logic [WAYS-1:0]            hit_vec;
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic [WAYS-1:0]            way_valid;
    logic [WAYS-1:0]            way_dirty;
    logic                       lru_way;
    logic                       hit_any;
    logic                       hit_way;
    logic                       victim_dirty;
    logic                       last_beat;

    logic              alloc_en, dirty_en, touch_en;
    logic              dat_we, dat_way;
    logic [WORD_W-1:0] dat_word;
    logic [DATA_W-1:0] dat_wdata, dat_rdata;

    assign req_set      = req_addr_q[OFF_W+SET_W-1:OFF_W];
    assign req_tag      = req_addr_q[ADDR_W-1:OFF_W+SET_W];
    assign req_word     = req_addr_q[OFF_W-1:2];
    assign hit_any      = |hit_vec;
    assign hit_way      = hit_vec[1];
    assign victim_dirty = way_valid[lru_way] && way_dirty[lru_way];
    assign last_beat    = (beat_q == WORD_W'(LINE_WORDS - 1));
    assign cpu_rdata    = rdata_q;

    wbdc_policy u_policy (
        .xlate_on  (xlate_on),
        .page_wt   (page_wt),
        .region_wt (region_wt),
        .region_ix (cpu_addr[ADDR_W-1 -: REG_W]),
        .thru      (cur_thru)
    );

    wbdc_tags u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (req_set),
        .tag_i     (req_tag),
        .alloc_en  (alloc_en),
        .alloc_way (way_q),
        .dirty_en  (dirty_en),
        .dirty_way (hit_way),
        .touch_en  (touch_en),
        .touch_way (hit_way),
        .hit_vec   (hit_vec),
        .way_tag   (way_tag),
        .way_valid (way_valid),
        .way_dirty (way_dirty),
        .lru_way   (lru_way)
    );

    wbdc_data u_data (
        .clk    (clk),
        .we     (dat_we),
        .set_i  (req_set),
        .way_i  (dat_way),
        .word_i (dat_word),
        .wdata  (dat_wdata),
        .rdata  (dat_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = req_addr_q;
        bus_wdata = req_wdata_q;
        alloc_en  = 1'b0;
        dirty_en  = 1'b0;
        touch_en  = 1'b0;
        dat_we    = 1'b0;
        dat_way   = (state_q == ST_LOOK) ? hit_way : way_q;
        dat_word  = (state_q == ST_EVICT || state_q == ST_REFILL) ? beat_q : req_word;
        dat_wdata = req_wdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_LOOK;
            end
            ST_LOOK: begin
                if (hit_any) begin
                    touch_en = 1'b1;
                    if (req_we_q) begin
                        dat_we   = 1'b1;
                        dirty_en = !req_thru_q;
                        state_d  = req_thru_q ? ST_WTHRU : ST_REPLY;
                    end else begin
                        state_d = ST_REPLY;
                    end
                end else if (!req_we_q && req_noalloc_q) begin
                    state_d = ST_SINGLE;
                end else begin
                    state_d = victim_dirty ? ST_EVICT : ST_REFILL;
                end
            end
            ST_EVICT: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = {way_tag[way_q], req_set, beat_q};
                bus_wdata = dat_rdata;
                if (bus_ack && last_beat) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                bus_req  = 1'b1;
                bus_addr = {req_tag, req_set, beat_q};
                if (bus_ack) begin
                    dat_we    = 1'b1;
                    dat_wdata = bus_rdata;
                    if (last_beat) begin
                        alloc_en = 1'b1;
                        state_d  = ST_LOOK;
                    end
                end
            end
            ST_SINGLE: begin
                bus_req = 1'b1;
                if (bus_ack) state_d = ST_REPLY;
            end
            ST_WTHRU: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                if (bus_ack) state_d = ST_REPLY;
            end
            ST_REPLY: begin
                cpu_ready = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // request capture and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q    <= '0;
            req_we_q      <= 1'b0;
            req_wdata_q   <= '0;
            req_thru_q    <= 1'b0;
            req_noalloc_q <= 1'b0;
            way_q         <= 1'b0;
            beat_q        <= '0;
            rdata_q       <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req) begin
                req_addr_q    <= cpu_addr;
                req_we_q      <= cpu_we;
                req_wdata_q   <= cpu_wdata;
                req_thru_q    <= cur_thru;
                req_noalloc_q <= load_noalloc;
            end
            if (state_q == ST_LOOK) begin
                if (hit_any) begin
                    if (!req_we_q) rdata_q <= dat_rdata;
                end else begin
                    way_q  <= lru_way;
                    beat_q <= '0;
                end
            end
            if ((state_q == ST_EVICT || state_q == ST_REFILL) && bus_ack)
                beat_q <= beat_q + 1'b1;
            if (state_q == ST_SINGLE && bus_ack)
                rdata_q <= bus_rdata;
        end
    end
endmodule

// File: rtl/wbdc_chk.sv
module wbdc_chk
    import wbdc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input ctl_state_t        state_q,
    input logic [WAYS-1:0]   hit_vec,
    input logic              hit_way,
    input logic [WAYS-1:0]   way_dirty,
    input logic              lru_way,
    input logic              req_we_q,
    input logic              req_thru_q,
    input logic              way_q,
    input logic [WORD_W-1:0] beat_q,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:2] bus_addr
);
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_fill_lru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL && bus_ack && beat_q == '1) |=> (lru_way == !$past(way_q)));

    p_wb_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOK && |hit_vec && req_we_q && !req_thru_q)
            |=> way_dirty[$past(hit_way)]);

    p_wt_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOK && |hit_vec && req_we_q && req_thru_q)
            |=> (way_dirty[$past(hit_way)] == $past(way_dirty[hit_way])));

    p_single_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SINGLE) |-> (bus_req && !bus_we));
endmodule

bind wb_dcache_ctrl wbdc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .hit_vec    (hit_vec),
    .hit_way    (hit_way),
    .way_dirty  (way_dirty),
    .lru_way    (lru_way),
    .req_we_q   (req_we_q),
    .req_thru_q (req_thru_q),
    .way_q      (way_q),
    .beat_q     (beat_q),
    .cpu_ready  (cpu_ready),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_ack    (bus_ack),
    .bus_addr   (bus_addr)
);

// File: tb/wb_dcache_ctrl_test.sv
`timescale 1ns/1ps
module wb_dcache_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:2] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        xlate_on = 1'b0, page_wt = 1'b0, load_noalloc = 1'b0;
    logic [31:0] region_wt = 32'h8000_0000;
    logic        cpu_ready, bus_req, bus_we;
    logic [31:0] cpu_rdata, bus_wdata;
    logic [31:2] bus_addr;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #5 clk = ~clk;

    wb_dcache_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .xlate_on(xlate_on),
        .page_wt(page_wt), .region_wt(region_wt), .load_noalloc(load_noalloc),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int nchk = 0, nbad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: memory image seen by the processor plus cache directory
    logic [31:0] truth  [logic [31:0]];
    logic [31:0] busmem [logic [31:0]];
    bit          m_vld [64][2];
    bit          m_drt [64][2];
    logic [20:0] m_tag [64][2];
    bit          m_lru [64];

    typedef struct packed { logic we; logic [31:0] a; logic [31:0] d; } busop_t;
    busop_t expq[$];
    busop_t obsq[$];

    function automatic logic [31:0] seed(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction
    function automatic logic [31:0] tval(input logic [31:0] a);
        return truth.exists(a) ? truth[a] : seed(a);
    endfunction
    function automatic logic [31:0] mval(input logic [31:0] a);
        return busmem.exists(a) ? busmem[a] : seed(a);
    endfunction

    // bus responder with a varying wait; watches every clock
    bit          pend = 1'b0;
    int          hold = 0;
    int          waitsel = 0;
    logic [31:0] paddr;
    logic        pwe;
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0;
            pend = 1'b0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (!pend) begin
                pend = 1'b1;
                paddr = {bus_addr, 2'b00};
                pwe = bus_we;
                waitsel = (waitsel + 1) % 3;
                hold = waitsel;
            end else begin
                chk({bus_addr, 2'b00} == paddr && bus_we == pwe, "R11",
                    "bus request held stable", {bus_addr, 2'b00}, paddr);
            end
            if (hold == 0) begin
                pend = 1'b0;
                bus_ack = 1'b1;
                if (bus_we) begin
                    busmem[{bus_addr, 2'b00}] = bus_wdata;
                    obsq.push_back({1'b1, bus_addr, 2'b00, bus_wdata});
                end else begin
                    bus_rdata = mval({bus_addr, 2'b00});
                    obsq.push_back({1'b0, bus_addr, 2'b00, 32'h0});
                end
            end else begin
                hold--;
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          input bit xl, input bit pw, input bit noal, input string req,
                          input bit want_fast);
        logic [5:0]  s;
        logic [20:0] t;
        logic [31:0] aw, exp_rd;
        bit          thru, fast;
        int          h, v, n;
        s = a[10:5];
        t = a[31:11];
        aw = {a[31:2], 2'b00};
        thru = xl ? pw : region_wt[a[31:27]];
        h = -1;
        exp_rd = '0;
        for (int w = 0; w < 2; w++) if (m_vld[s][w] && m_tag[s][w] == t) h = w;
        fast = (h >= 0) && !(we && thru);
        if (h < 0) begin
            if (!we && noal) begin
                expq.push_back({1'b0, aw, 32'h0});
                exp_rd = tval(aw);
            end else begin
                v = m_lru[s] ? 1 : 0;
                if (m_vld[s][v] && m_drt[s][v])
                    for (int k = 0; k < 8; k++) begin
                        logic [31:0] ea;
                        ea = {m_tag[s][v], s, k[2:0], 2'b00};
                        expq.push_back({1'b1, ea, tval(ea)});
                    end
                for (int k = 0; k < 8; k++)
                    expq.push_back({1'b0, t, s, k[2:0], 2'b00, 32'h0});
                m_vld[s][v] = 1'b1;
                m_tag[s][v] = t;
                m_drt[s][v] = 1'b0;
                h = v;
            end
        end
        if (h >= 0) begin
            m_lru[s] = (h == 0);
            if (we) begin
                truth[aw] = wd;
                if (thru) expq.push_back({1'b1, aw, wd});
                else      m_drt[s][h] = 1'b1;
            end else begin
                exp_rd = tval(aw);
            end
        end
        // drive the request
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a[31:2]; cpu_wdata = wd;
        xlate_on = xl; page_wt = pw; load_noalloc = noal;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 400);
        chk(cpu_ready, req, "request completed", 32'(cpu_ready), 32'h1);
        if (!we) chk(cpu_rdata == exp_rd, req, "load data", cpu_rdata, exp_rd);
        if (want_fast && fast) chk(n == 2, "R1", "hit latency", n, 2);
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_ready && !bus_req, "R10", "idle between requests",
            {30'h0, cpu_ready, bus_req}, 32'h0);
        chk(obsq.size() == expq.size(), req, "bus transfer count", obsq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < obsq.size(); i++) begin
            chk(obsq[i].we == expq[i].we && obsq[i].a == expq[i].a, req,
                "bus transfer address", {obsq[i].a[31:1], obsq[i].we},
                {expq[i].a[31:1], expq[i].we});
            if (expq[i].we)
                chk(obsq[i].d == expq[i].d, req, "bus write data", obsq[i].d, expq[i].d);
        end
        obsq.delete();
        expq.delete();
    endtask

    initial begin
        #1_500_000;
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int rng;
        for (int i = 0; i < 64; i++) begin
            m_lru[i] = 1'b0;
            for (int w = 0; w < 2; w++) begin m_vld[i][w] = 1'b0; m_drt[i][w] = 1'b0; end
        end
        repeat (4) @(negedge clk);
        chk(!cpu_ready && !bus_req, "R10", "reset outputs", {30'h0, cpu_ready, bus_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !bus_req, "R10", "after reset", {30'h0, cpu_ready, bus_req}, 32'h0);

        access(0, 32'h0000_1004, 0, 1, 0, 0, "R7", 1);           // miss: line fill into way 0
        access(0, 32'h0000_1010, 0, 1, 0, 0, "R1", 1);           // hit
        access(1, 32'h0000_1008, 32'hCAFE_0001, 1, 0, 0, "R3", 1); // write-back store hit
        access(0, 32'h0000_1008, 0, 1, 0, 0, "R3", 1);
        access(0, 32'h0000_2000, 0, 1, 0, 0, "R2", 1);           // fills way 1
        access(0, 32'h0000_1000, 0, 1, 0, 0, "R2", 1);           // touch way 0
        access(0, 32'h0000_3000, 0, 1, 0, 0, "R2", 1);           // evicts clean way 1
        access(0, 32'h0000_4000, 0, 1, 0, 0, "R8", 1);           // evicts dirty way 0
        access(1, 32'h0000_4004, 32'hBEEF_0002, 1, 1, 0, "R4", 1); // write-through hit
        access(0, 32'h0000_5000, 0, 1, 0, 0, "R2", 1);
        access(0, 32'h0000_6000, 0, 1, 0, 0, "R4", 1);           // victim stayed clean
        access(1, 32'hF800_0040, 32'h1111_2222, 0, 0, 0, "R5", 1); // region 31 write-through
        access(1, 32'h0800_0040, 32'h3333_4444, 0, 1, 0, "R9", 1); // region 1 write-back
        access(1, 32'hF800_0044, 32'h5555_6666, 1, 0, 0, "R5", 1); // page overrides region
        access(0, 32'h0001_2000, 0, 1, 0, 1, "R6", 1);           // single word
        access(0, 32'h0001_2000, 0, 1, 0, 1, "R6", 1);           // still not allocated
        access(0, 32'hF800_0044, 0, 1, 0, 1, "R6", 1);           // hit unaffected

        rng = 32'h1234_5677;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >>> 17);
            rng = rng ^ (rng << 5);
            a = (32'(rng[2:0]) << 12) | (32'(rng[5:4]) << 5) | (32'(rng[8:6]) << 2);
            if (rng[9]) a = a | 32'hF800_0000;
            access(rng[12], a, rng ^ 32'h00FF_00FF, rng[10], rng[11], rng[13], "R9", 1);
        end

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule